// File: doc/BRIEF.md
# Flag-Setting 16-Bit Microcode ALU

This block is the arithmetic and logic stage of a small 16-bit microcode engine. Each operation takes two 16-bit operands, a 4-bit opcode and two carry qualifiers, and produces a 16-bit result in the same cycle. Addition and subtraction can optionally consume the stored carry flag and can optionally write it back. Every other operation leaves the flag alone. The operation set also covers the three bitwise logic operations and a clear-bits operation. It includes left, logical right and arithmetic right shifts and both rotate directions. Two extended operations take two small immediates, a field width minus one and a shift count. One pulls a field out of a register pair. The other inserts a field into a register.

Operations enter through a valid/ready stream and leave through one. The datapath has no storage, so the input side is ready exactly when the output side is ready. An operation counts as accepted on a clock edge where `in_valid` and `out_ready` are both high. Back-pressure on the output stalls the input in the same cycle. While it is stalled, nothing is accepted and the carry flag cannot change. The result is valid whenever `out_valid` is high and follows the inputs combinationally.

Top module: `mc_alu16`

## Requirements
- R1: Reset (`rst_n` low) clears `carry_flag` to 0.
- R2: Opcode 0 (add) gives `result = opa + opb + ci` modulo 2^16. `ci` is `carry_flag` when `use_carry` is 1 and 0 otherwise. The carry-out is bit 16 of the full sum.
- R3: Opcode 1 (subtract) gives `result = opa + ~opb + ci` modulo 2^16. `ci` is `carry_flag` when `use_carry` is 1 and 1 otherwise, so the flag acts as not-borrow. The carry-out is bit 16 of that sum and is 1 when no borrow occurs.
- R4: `carry_flag` takes the carry-out only on an accepted add or subtract with `set_carry` = 1. It holds its value for every other opcode, for any operation with `set_carry` = 0, and in any cycle with no acceptance.
- R5: Opcodes 2, 3 and 4 give OR, AND and XOR of `opa` and `opb`. Opcode 5 (clear-bits) gives `opa & ~opb`.
- R6: Opcode 6 shifts `opa` left, opcode 7 shifts it logically right and opcode 8 shifts it arithmetically right. Each shift is by `opb[3:0]`, and `opb[15:4]` has no effect.
- R7: Opcode 9 rotates `opa` left and opcode 10 rotates it right, each by `opb[3:0]`. A count of 0 returns `opa` unchanged.
- R8: Opcode 11 (field extract) gives `({opb,opa} >> ext_s)` masked to its low `ext_w+1` bits.
- R9: Opcode 12 (field insert) takes the low `ext_w+1` bits of `opa`, shifts them left by `ext_s` and places them into `opb`. All bits of `opb` outside the shifted mask are kept, and bits shifted past bit 15 are dropped.
- R10: Opcodes 13 to 15 give a result of 0 and never change `carry_flag`.
- R11: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the input side |
| in_ready | output | 1 | Operation can be accepted |
| opcode | input | 4 | Operation select |
| use_carry | input | 1 | Add/subtract consume the stored carry |
| set_carry | input | 1 | Add/subtract write the carry flag |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand; its low 4 bits are the shift/rotate count |
| ext_w | input | 4 | Extended ops: field width minus one |
| ext_s | input | 4 | Extended ops: shift count |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 16 | Operation result |
| carry_flag | output | 1 | Stored carry flag |

## Verification
Several rules are checked on every cycle:
- the carry flag holds outside accepted flag-writing add or subtract operations;
- an add or subtract without carry-in reports carry or no-borrow consistently with an unsigned compare;
- rotates preserve the number of set bits;
- an extracted field never has bits above its width;
- an insert never disturbs bits outside the shifted field;
- spare opcodes return zero;
- the stall rule holds.

The exact values need the bench's scenarios:
- carry chaining across consecutive operations;
- sign fill of the arithmetic shift;
- extraction that spans the register pair;
- insertion that runs off the top of the word;
- the flag surviving a stalled cycle and being cleared by a reset in the middle of a run.

// File: rtl/mcalu_pkg.sv
package mcalu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_OR   = 4'd2,
    OP_AND  = 4'd3,
    OP_XOR  = 4'd4,
    OP_CLR  = 4'd5,
    OP_SHL  = 4'd6,
    OP_SHR  = 4'd7,
    OP_SHRA = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_XSHR = 4'd11,
    OP_XINS = 4'd12
  } mc_op_e;
endpackage

// File: rtl/mcalu_addsub.sv
module mcalu_addsub #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_sub,
  input  logic         use_carry,
  input  logic         cf,
  output logic [W-1:0] y,
  output logic         co
);
  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   full;

  always_comb begin
    b_eff = is_sub ? ~b : b;
    // subtract without carry-in is a + ~b + 1; with carry-in the flag is not-borrow
    cin   = use_carry ? cf : is_sub;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    y     = full[W-1:0];
    co    = full[W];
  end

  // R2: a plain add carries exactly when the sum wrapped below the first operand
  p_add_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_sub && !use_carry) |-> (co == (y < a)));

  // R3: a plain subtract reports no-borrow exactly when a >= b
  p_sub_noborrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sub && !use_carry) |-> (co == (a >= b)));
endmodule

// File: rtl/mcalu_shift.sv
module mcalu_shift
  import mcalu_pkg::*;
#(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  mc_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   y
);
  logic [2*W-1:0] dbl_l;
  logic [2*W-1:0] dbl_r;
  logic [W-1:0]   sra_v;

  always_comb begin
    dbl_l = {a, a} << amt;
    dbl_r = {a, a} >> amt;
    sra_v = $unsigned($signed(a) >>> amt);
    case (op)
      OP_SHL:  y = a << amt;
      OP_SHR:  y = a >> amt;
      OP_SHRA: y = sra_v;
      OP_ROL:  y = dbl_l[2*W-1:W];
      OP_ROR:  y = dbl_r[W-1:0];
      default: y = '0;
    endcase
  end

  // R7: rotation neither creates nor loses set bits
  p_rot_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL || op == OP_ROR) |-> ($countones(y) == $countones(a)));

  // R6: a logical right shift never grows the value
  p_shr_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHR) |-> (y <= a));
endmodule

// File: rtl/mcalu_field.sv
module mcalu_field #(
  parameter int W   = 16,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           insert,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SHW-1:0] fw,
  input  logic [SHW-1:0] fs,
  output logic [W-1:0]   y
);
  logic [W-1:0]   mask;
  logic [2*W-1:0] pair_sh;
  logic [W-1:0]   mask_sh;
  logic [W-1:0]   fld_sh;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = (g <= int'(fw));
  end

  always_comb begin
    pair_sh = {b, a} >> fs;
    mask_sh = mask << fs;
    fld_sh  = (a & mask) << fs;
    if (insert) y = (b & ~mask_sh) | fld_sh;
    else        y = pair_sh[W-1:0] & mask;
  end

  // R8: an extracted field has no bits above its width
  p_extract_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !insert |-> ((y & ~mask) == '0));

  // R9: insertion leaves every bit outside the shifted field as in b
  p_insert_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    insert |-> (((y ^ b) & ~(mask << fs)) == '0));
endmodule

// File: rtl/mc_alu16.sv
module mc_alu16
  import mcalu_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       opcode,
  input  logic             use_carry,
  input  logic             set_carry,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [SHW-1:0]   ext_w,
  input  logic [SHW-1:0]   ext_s,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] result,
  output logic             carry_flag
);
  mc_op_e           op;
  logic             fire;
  logic             is_arith;
  logic [WIDTH-1:0] as_y;
  logic             as_co;
  logic [WIDTH-1:0] sh_y;
  logic [WIDTH-1:0] fx_y;

  assign op        = mc_op_e'(opcode);
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign fire      = in_valid && out_ready;
  assign is_arith  = (op == OP_ADD) || (op == OP_SUB);

  mcalu_addsub #(.W(WIDTH)) u_addsub (
    .clk(clk), .rst_n(rst_n), .a(opa), .b(opb),
    .is_sub(op == OP_SUB), .use_carry(use_carry), .cf(carry_flag),
    .y(as_y), .co(as_co)
  );

  mcalu_shift #(.W(WIDTH), .SHW(SHW)) u_shift (
    .clk(clk), .rst_n(rst_n), .op(op), .a(opa), .amt(opb[SHW-1:0]), .y(sh_y)
  );

  mcalu_field #(.W(WIDTH), .SHW(SHW)) u_field (
    .clk(clk), .rst_n(rst_n), .insert(op == OP_XINS), .a(opa), .b(opb),
    .fw(ext_w), .fs(ext_s), .y(fx_y)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                     result = as_y;
      OP_OR:                              result = opa | opb;
      OP_AND:                             result = opa & opb;
      OP_XOR:                             result = opa ^ opb;
      OP_CLR:                             result = opa & ~opb;
      OP_SHL, OP_SHR, OP_SHRA,
      OP_ROL, OP_ROR:                     result = sh_y;
      OP_XSHR, OP_XINS:                   result = fx_y;
      default:                            result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               carry_flag <= 1'b0;
    else if (fire && set_carry && is_arith)   carry_flag <= as_co;
  end

  // R4: flag holds unless an accepted flag-writing add/subtract occurs
  p_carry_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && set_carry && is_arith) |=> $stable(carry_flag));

  // R10: spare opcodes yield zero
  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode > 4'd12) |-> (result == '0));

  // R11: a stalled output stalls the input
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/mc_alu16_tb.sv
module mc_alu16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  opcode = 4'd0;
  logic        use_carry = 1'b0;
  logic        set_carry = 1'b0;
  logic [15:0] opa = '0;
  logic [15:0] opb = '0;
  logic [3:0]  ext_w = '0;
  logic [3:0]  ext_s = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] result;
  logic        carry_flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mc_alu16 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opcode(opcode), .use_carry(use_carry), .set_carry(set_carry),
    .opa(opa), .opb(opb), .ext_w(ext_w), .ext_s(ext_s),
    .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .carry_flag(carry_flag)
  );

  // {op, use_carry, set_carry, a, b, ext_w, ext_s, expected result, expected flag after edge}
  localparam int NV = 22;
  localparam logic [62:0] VEC [NV] = '{
    {4'd0, 1'b0, 1'b1, 16'hFFFF, 16'h0001, 4'd0, 4'd0, 16'h0000, 1'b1},
    {4'd0, 1'b1, 1'b0, 16'h0001, 16'h0002, 4'd0, 4'd0, 16'h0004, 1'b1},
    {4'd0, 1'b1, 1'b1, 16'h8000, 16'h7FFF, 4'd0, 4'd0, 16'h0000, 1'b1},
    {4'd1, 1'b0, 1'b1, 16'h0005, 16'h0007, 4'd0, 4'd0, 16'hFFFE, 1'b0},
    {4'd1, 1'b1, 1'b1, 16'h0010, 16'h0003, 4'd0, 4'd0, 16'h000C, 1'b1},
    {4'd1, 1'b0, 1'b0, 16'h1234, 16'h1234, 4'd0, 4'd0, 16'h0000, 1'b1},
    {4'd2, 1'b0, 1'b1, 16'hF0F0, 16'h0FF0, 4'd0, 4'd0, 16'hFFF0, 1'b1},
    {4'd3, 1'b0, 1'b0, 16'hF0F0, 16'h0FF0, 4'd0, 4'd0, 16'h00F0, 1'b1},
    {4'd4, 1'b0, 1'b0, 16'hF0F0, 16'h0FF0, 4'd0, 4'd0, 16'hFF00, 1'b1},
    {4'd5, 1'b0, 1'b0, 16'hF0F0, 16'h0FF0, 4'd0, 4'd0, 16'hF000, 1'b1},
    {4'd6, 1'b0, 1'b0, 16'h8001, 16'h0013, 4'd0, 4'd0, 16'h0008, 1'b1},
    {4'd7, 1'b0, 1'b0, 16'h8001, 16'hFFF4, 4'd0, 4'd0, 16'h0800, 1'b1},
    {4'd8, 1'b0, 1'b0, 16'h8001, 16'h0004, 4'd0, 4'd0, 16'hF800, 1'b1},
    {4'd9, 1'b0, 1'b0, 16'h8001, 16'h0004, 4'd0, 4'd0, 16'h0018, 1'b1},
    {4'd10,1'b0, 1'b0, 16'h8001, 16'h0004, 4'd0, 4'd0, 16'h1800, 1'b1},
    {4'd9, 1'b0, 1'b0, 16'h1234, 16'h0010, 4'd0, 4'd0, 16'h1234, 1'b1},
    {4'd11,1'b0, 1'b0, 16'hABCD, 16'h1234, 4'd7, 4'd8, 16'h00AB, 1'b1},
    {4'd11,1'b0, 1'b0, 16'hABCD, 16'h1234, 4'd7, 4'd12,16'h004A, 1'b1},
    {4'd11,1'b0, 1'b0, 16'hABCD, 16'h1234, 4'd15,4'd0, 16'hABCD, 1'b1},
    {4'd12,1'b0, 1'b0, 16'h00A5, 16'hFFFF, 4'd3, 4'd4, 16'hFF5F, 1'b1},
    {4'd12,1'b0, 1'b0, 16'h000D, 16'h1234, 4'd3, 4'd14,16'h5234, 1'b1},
    {4'd13,1'b0, 1'b1, 16'hFFFF, 16'h0001, 4'd0, 4'd0, 16'h0000, 1'b1}
  };

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0:                     return "R2";
      4'd1:                     return "R3";
      4'd2, 4'd3, 4'd4, 4'd5:   return "R5";
      4'd6, 4'd7, 4'd8:         return "R6";
      4'd9, 4'd10:              return "R7";
      4'd11:                    return "R8";
      4'd12:                    return "R9";
      default:                  return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic uc, input logic sc,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic [3:0] w, input logic [3:0] s);
    @(negedge clk);
    in_valid = 1'b1; opcode = o; use_carry = uc; set_carry = sc;
    opa = a; opb = b; ext_w = w; ext_s = s;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 flag after reset", {15'd0, carry_flag}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      v = VEC[i];
      drive(v[62:59], v[58], v[57], v[56:41], v[40:25], v[24:21], v[20:17]);
      check(tag_of(v[62:59]), result, v[16:1]);
      @(posedge clk); #1;
      check({tag_of(v[62:59]), "/R4 flag"}, {15'd0, carry_flag}, {15'd0, v[0]});
    end

    // R11 and R4: stall blocks a flag-writing subtract (flag is 1, would become 0)
    out_ready = 1'b0;
    drive(4'd1, 1'b0, 1'b1, 16'h0001, 16'h0002, 4'd0, 4'd0);
    check("R11 in_ready under stall", {15'd0, in_ready}, 16'd0);
    check("R11 out_valid follows in_valid", {15'd0, out_valid}, 16'd1);
    @(posedge clk); #1;
    check("R4 flag held while stalled", {15'd0, carry_flag}, 16'd1);
    out_ready = 1'b1;
    #1 check("R11 in_ready follows out_ready", {15'd0, in_ready}, 16'd1);

    // R4: no valid, no update
    in_valid = 1'b0;
    @(posedge clk); #1;
    check("R4 flag held without valid", {15'd0, carry_flag}, 16'd1);
    check("R11 out_valid low", {15'd0, out_valid}, 16'd0);

    // R2: carry consumed from flag (1): 0x00FF + 0x0000 + 1
    drive(4'd0, 1'b1, 1'b0, 16'h00FF, 16'h0000, 4'd0, 4'd0);
    check("R2 add uses carry", result, 16'h0100);
    @(posedge clk); #1;

    // R3: borrow-out clears the flag, then subtract with borrow
    drive(4'd1, 1'b0, 1'b1, 16'h0000, 16'h0001, 4'd0, 4'd0);
    check("R3 sub borrow result", result, 16'hFFFF);
    @(posedge clk); #1;
    check("R3 borrow clears flag", {15'd0, carry_flag}, 16'd0);
    drive(4'd1, 1'b1, 1'b0, 16'h0005, 16'h0001, 4'd0, 4'd0);
    check("R3 sub with borrow-in", result, 16'h0003);
    @(posedge clk); #1;

    // R1: reset mid-run clears a set flag
    drive(4'd0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0);
    @(posedge clk); #1;
    check("R2 flag set before reset", {15'd0, carry_flag}, 16'd1);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 flag cleared by reset", {15'd0, carry_flag}, 16'd0);
    rst_n = 1'b1;

    // R10: spare opcode 15 with flag write leaves flag at 0
    drive(4'd15, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0);
    check("R10 spare opcode result", result, 16'h0000);
    @(posedge clk); #1;
    check("R10 spare opcode flag", {15'd0, carry_flag}, 16'd0);
    in_valid = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule